// File: doc/BRIEF.md
# Sprite Memory Page Copy Engine

This block copies one 256-byte page from the system address space into the sprite attribute data port of a video unit. Software starts it by writing a page number to a trigger address, 0x4014. From the cycle after that write, the engine owns the system bus and holds the CPU stalled. For each byte, it issues a bus read from the source page and then a bus write of the same byte to the fixed port address 0x2004. When all 256 bytes are stored, it releases the bus and pulses a done flag for one cycle.

Reads are aligned to CPU cycle parity. A read is issued only in a cycle where the parity input is high, so the engine may spend one extra cycle (or more, if parity stays low) before a read. The controller is a four-state machine:

- **PASSIVE**: the engine is off.
- **IDLE**: lasts one cycle and holds the source address.
- **FETCH**: the engine waits for an odd cycle and then reads.
- **STORE**: the engine writes the latched byte to the port.

The transitions are:

- **trigger**: PASSIVE to IDLE, on a write to the trigger address.
- **arm**: IDLE to FETCH, always after one cycle.
- **read**: FETCH to STORE, when the parity input is high.
- **hold**: FETCH to FETCH, when the parity input is low.
- **next**: STORE to FETCH, when bytes remain.
- **finish**: STORE to PASSIVE, after the last byte.

Top module: `spr_dma_top`

## Requirements
- R1: While `rst` is high at a clock edge, the engine returns to PASSIVE and clears the latched byte. After reset, `cpu_stall`, `bus_rd`, `bus_wr` and `done` are all low.
- R2: A write with `cpu_wr_en` high, `cpu_addr` = 0x4014 and `cpu_wdata` = P, made while PASSIVE, starts a copy of source page P (source address P×256). In the next cycle, `cpu_stall` is high and neither bus strobe is active (IDLE).
- R3: A write to any other address has no effect. A trigger write made while the engine is busy also has no effect. In both cases the stall output, the transfer length and the source page are unchanged.
- R4: `bus_rd` is asserted only in cycles where `cyc_odd` is high. In FETCH with `cyc_odd` low, the engine waits and issues no strobe.
- R5: Every read is followed, in the very next cycle, by a write with `bus_addr` = 0x2004 and `bus_wdata` equal to the byte that was read.
- R6: The reads visit the addresses P×256+0 through P×256+255 in ascending order. Exactly 256 reads and 256 writes occur per transfer.
- R7: `cpu_stall` is high from the cycle after the trigger write through the cycle of the final write. With `cyc_odd` alternating, this is 513 cycles when the first FETCH cycle is odd and 514 when it is even. Each extra cycle with parity forced low lengthens it by the reads it delays.
- R8: `done` is high for exactly one cycle, the first cycle after the final write, and is otherwise low.
- R9: A reset during a transfer drops the stall and both strobes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | CPU write strobe, used for trigger decode |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data (the page number) |
| cyc_odd | input | 1 | High in odd CPU cycles |
| bus_addr | output | 16 | Bus address driven by the engine |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid in the cycle of `bus_rd` |
| cpu_stall | output | 1 | Holds the CPU off while the engine is active |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench aims at several corner cases, each with a distinct failure mode:

- **Parity of the first FETCH cycle.** The bench starts transfers with the first FETCH cycle on both parities. A missing alignment wait would give 513 stall cycles where 514 are expected, or would issue a read on an even cycle.
- **Parity held low mid-transfer.** This shows that a write is never deferred and a read is never skipped.
- **Trigger rewrite during a transfer.** A rewrite that was not ignored would either restart the count, which stretches the stall, or switch the source page, which the scoreboard catches on the read addresses.
- **Boundary pages and reset.** Pages 0x00 and 0xFF catch carry errors in the address. A mid-transfer reset must drop the stall at once, and a later transfer must still start cleanly.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    typedef enum logic [1:0] {
        ST_PASSIVE = 2'd0,
        ST_IDLE    = 2'd1,
        ST_FETCH   = 2'd2,
        ST_STORE   = 2'd3
    } dma_state_t;

endpackage

// File: rtl/spr_dma_trig.sv
module spr_dma_trig #(
    parameter int ADDR_W    = 16,
    parameter int TRIG_ADDR = 16'h4014
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

    always_comb begin
        hit = wr_en && (addr == TRIG);
    end
endmodule

// File: rtl/spr_dma_ptr.sv
module spr_dma_ptr #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] page_in,
    input  logic              arm,
    input  logic              fetch,
    input  logic              store,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] held,
    output logic              last
);
    localparam int PAGE_W = ADDR_W - CNT_W;

    logic [CNT_W-1:0] remain;
    logic [PAGE_W-1:0] page;

    always_comb begin
        page = PAGE_W'(page_in);
        last = (remain == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
            held     <= '0;
        end else begin
            if (load) begin
                cur_addr <= {page, {CNT_W{1'b0}}};
            end
            if (arm) begin
                remain <= '1;
            end
            if (fetch) begin
                held <= rdata;
            end
            if (store) begin
                held <= '0;
                if (!last) begin
                    cur_addr <= cur_addr + 1'b1;
                    remain   <= remain - 1'b1;
                end
            end
        end
    end

    // R6: the source address is held between a read and its write
    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        fetch |=> $stable(cur_addr));

    // R5: the byte driven out during a write is the byte captured by the read
    p_held_data_r5: assert property (@(posedge clk) disable iff (rst)
        fetch |=> (held == $past(rdata)));
endmodule

// File: rtl/spr_dma_fsm.sv
module spr_dma_fsm
    import spr_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_hit,
    input  logic cyc_odd,
    input  logic last,
    output logic load,
    output logic arm,
    output logic fetch,
    output logic store,
    output logic stall,
    output logic done
);
    dma_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PASSIVE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_STORE) && last;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        arm      = 1'b0;
        fetch    = 1'b0;
        store    = 1'b0;
        stall    = 1'b1;
        unique case (state)
            ST_PASSIVE: begin
                stall = 1'b0;
                if (trig_hit) begin
                    load     = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_IDLE: begin
                arm      = 1'b1;
                state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                if (cyc_odd) begin
                    fetch    = 1'b1;
                    state_nx = ST_STORE;
                end
            end
            ST_STORE: begin
                store    = 1'b1;
                state_nx = last ? ST_PASSIVE : ST_FETCH;
            end
        endcase
    end

    // R4: reads only on odd cycles
    p_rd_odd_r4: assert property (@(posedge clk) disable iff (rst)
        fetch |-> cyc_odd);

    // R5: every read is followed by a write
    p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (rst)
        fetch |=> store);

    // R5: never both strobes
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(fetch && store));

    // R8: done is a single pulse following a write
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!stall && $past(store)));
endmodule

// File: rtl/spr_dma_top.sv
module spr_dma_top #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int TRIG_ADDR = 16'h4014,
    parameter int PORT_ADDR = 16'h2004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cyc_odd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_stall,
    output logic              done
);
    localparam logic [ADDR_W-1:0] PORT = ADDR_W'(PORT_ADDR);

    logic trig_hit, load, arm, fetch, store, last;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] held;

    spr_dma_trig #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_trig (
        .wr_en (cpu_wr_en),
        .addr  (cpu_addr),
        .hit   (trig_hit)
    );

    spr_dma_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trig_hit (trig_hit),
        .cyc_odd  (cyc_odd),
        .last     (last),
        .load     (load),
        .arm      (arm),
        .fetch    (fetch),
        .store    (store),
        .stall    (cpu_stall),
        .done     (done)
    );

    spr_dma_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .page_in  (cpu_wdata),
        .arm      (arm),
        .fetch    (fetch),
        .store    (store),
        .rdata    (bus_rdata),
        .cur_addr (cur_addr),
        .held     (held),
        .last     (last)
    );

    always_comb begin
        bus_rd    = fetch;
        bus_wr    = store;
        bus_addr  = store ? PORT : cur_addr;
        bus_wdata = held;
    end

    // R2: a trigger write while passive starts the stall with no bus traffic
    p_trig_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && cpu_wr_en && cpu_addr == ADDR_W'(TRIG_ADDR))
            |=> (cpu_stall && !bus_rd && !bus_wr));

    // R5: writes always target the port address
    p_wr_port_r5: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (bus_addr == PORT));

    // R3: a write elsewhere while passive leaves the engine passive
    p_other_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && !(cpu_wr_en && cpu_addr == ADDR_W'(TRIG_ADDR)))
            |=> !cpu_stall);
endmodule

// File: tb/spr_dma_top_tb.sv
module spr_dma_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cyc_odd;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        cpu_stall, done;

    logic [31:0] tb_cyc = '0;
    logic        hold_req = 1'b0;
    logic        hold_even = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [15:0] exp_rd[$];
    logic [7:0]  exp_wr[$];
    logic        prev_rd = 1'b0;
    logic [15:0] e_addr;
    logic [7:0]  e_data;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tb_cyc    <= tb_cyc + 1;
        hold_even <= hold_req;
    end
    assign cyc_odd = tb_cyc[0] & ~hold_even;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
    endfunction
    assign bus_rdata = mem_byte(bus_addr);

    spr_dma_top u_dut (
        .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cyc_odd(cyc_odd), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as the design drives the bus
    always @(negedge clk) begin
        if (rst) begin
            prev_rd = 1'b0;
        end else begin
            if (bus_rd) begin
                chk(cyc_odd, "R4", "read on even cycle", 32'(cyc_odd), 1);
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R6", "unexpected read", 32'(bus_addr), 0);
                end else begin
                    e_addr = exp_rd.pop_front();
                    chk(bus_addr == e_addr, "R6", "read address", 32'(bus_addr), 32'(e_addr));
                end
            end
            if (bus_wr) begin
                chk(prev_rd, "R5", "write not preceded by read", 32'(prev_rd), 1);
                chk(bus_addr == 16'h2004, "R5", "write address", 32'(bus_addr), 32'h2004);
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R6", "unexpected write", 32'(bus_wdata), 0);
                end else begin
                    e_data = exp_wr.pop_front();
                    chk(bus_wdata == e_data, "R5", "write data", 32'(bus_wdata), 32'(e_data));
                end
            end
            prev_rd = bus_rd;
        end
    end

    // driver: pushes expected items, triggers, and times the stall
    task automatic run_xfer(input logic [7:0] page, input bit want_odd,
                            input int poke_at, input int hold_at,
                            input int hold_len, input int abort_at);
        int scnt;
        int expect_len;
        for (int i = 0; i < 256; i++) begin
            exp_rd.push_back({page, 8'(i)});
            exp_wr.push_back(mem_byte({page, 8'(i)}));
        end
        @(negedge clk);
        while (tb_cyc[0] != want_odd) @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = 16'h4014; cpu_wdata = page;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        // R2: idle cycle
        chk(cpu_stall && !bus_rd && !bus_wr, "R2", "idle cycle after trigger",
            {29'd0, cpu_stall, bus_rd, bus_wr}, 32'h4);
        scnt = 0;
        while (cpu_stall && scnt < 3000) begin
            scnt++;
            if (scnt == poke_at) begin
                cpu_wr_en = 1'b1; cpu_addr = 16'h4014; cpu_wdata = 8'h77;
            end else begin
                cpu_wr_en = 1'b0;
            end
            if (scnt == hold_at) hold_req = 1'b1;
            if (scnt == hold_at + hold_len) hold_req = 1'b0;
            if (scnt == abort_at) begin
                rst = 1'b1;
                @(negedge clk);
                // R9: reset mid-transfer
                chk(!cpu_stall && !bus_rd && !bus_wr && !done, "R9", "abort by reset",
                    {28'd0, cpu_stall, bus_rd, bus_wr, done}, 0);
                rst = 1'b0;
                exp_rd.delete();
                exp_wr.delete();
                return;
            end
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;
        expect_len = (want_odd ? 513 : 514) + ((hold_at > 0) ? hold_len : 0);
        chk(scnt == expect_len, "R7", "stall length", 32'(scnt), 32'(expect_len));
        chk(done, "R8", "done in first cycle after last write", 32'(done), 1);
        chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R6", "all bytes moved",
            32'(exp_rd.size() + exp_wr.size()), 0);
        @(negedge clk);
        chk(!done, "R8", "done lasts one cycle", 32'(done), 0);
        chk(!cpu_stall, "R3", "no restart from ignored trigger", 32'(cpu_stall), 0);
        exp_rd.delete();
        exp_wr.delete();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cpu_stall == 1'b0 && bus_rd == 1'b0 && bus_wr == 1'b0 && done == 1'b0,
            "R1", "outputs during reset", {28'd0, cpu_stall, bus_rd, bus_wr, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_stall && !done, "R1", "outputs after reset",
            {30'd0, cpu_stall, done}, 0);

        // R3: write to a different address is ignored
        cpu_wr_en = 1'b1; cpu_addr = 16'h4015; cpu_wdata = 8'h02;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        chk(!cpu_stall && !bus_rd && !bus_wr, "R3", "other address ignored",
            {29'd0, cpu_stall, bus_rd, bus_wr}, 0);
        @(negedge clk);
        chk(!cpu_stall, "R3", "still passive", 32'(cpu_stall), 0);

        run_xfer(8'h02, 1'b1, -1, -1, 0, -1);   // R7 odd alignment
        run_xfer(8'h80, 1'b0, -1, -1, 0, -1);   // R7 even alignment, R4 wait
        run_xfer(8'h00, 1'b1, 100, -1, 0, -1);  // R3 trigger while busy
        run_xfer(8'hFF, 1'b1, -1, 60, 4, -1);   // R4 parity held low
        run_xfer(8'h33, 1'b1, -1, -1, 0, 30);   // R9 abort
        @(negedge clk);
        chk(!cpu_stall && !done, "R9", "passive after abort",
            {30'd0, cpu_stall, done}, 0);
        run_xfer(8'h05, 1'b0, -1, -1, 0, -1);   // R2 clean restart after abort

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule